// File: doc/BRIEF.md
# Reconfigurable Reed-Solomon Encoder

A systematic Reed-Solomon encoder over GF(2^8) for a memory array where each 8-bit symbol lands in its own storage package. It receives a stream of data symbols under valid/ready flow control. A start-of-word flag opens each codeword. The data passes straight to the output, and the encoder then appends the parity symbols for the code chosen at the start of that word.

Four codes are supported, and all of them keep the same data-to-codeword ratio of 8/9: RS(18,16), RS(36,32), RS(72,64) and RS(144,128). This lets the owning controller trade decode latency against correction strength without changing the share of storage spent on check bytes. A single division register, sized for the longest code, serves all four codes. The selected code decides how many of its stages are active. A code change requested while a word is in flight waits until that word has closed.

Top module: `rs_var_enc`

## Requirements
- R1: After reset the block is idle: busy_o is low, and out_valid_o stays low while no start-flagged symbol is offered.
- R2: cfg_code_i value c selects a code with 16<<c data symbols and 2<<c parity symbols: 0 gives (18,16), 1 gives (36,32), 2 gives (72,64) and 3 gives (144,128). The first parity symbol follows exactly that many data symbols.
- R3: Each accepted data symbol appears on out_data_o unchanged, in order, in the cycle it is accepted. out_sow_o is high on the first symbol of a word only.
- R4: The parity symbols are the remainder of m(x)·x^(2t) modulo g(x), where m(x) is the data with the first symbol as the highest-degree term, g(x) has roots alpha^0..alpha^(2t-1), and the field polynomial is x^8+x^4+x^3+x^2+1. They are sent highest degree first, and out_eow_o marks the last one.
- R5: During the parity phase in_ready_o is low and out_valid_o is high. A parity symbol stays stable on out_data_o until out_ready_i accepts it.
- R6: A codeword opens only when a symbol with in_sow_i high is accepted while idle. Idle symbols with in_sow_i low are consumed (in_ready_o high) and dropped (out_valid_o low).
- R7: Inside a codeword in_sow_i is ignored: the symbol counts as data and out_sow_o stays low.
- R8: cfg_code_i is sampled only when the first symbol of a word is accepted. Changes at any other time take effect from the next word.
- R9: busy_o rises in the cycle after a word's first symbol is accepted and falls in the cycle after its last parity symbol is accepted.
- R10: The division register clears at the start of every word, so a word's parity depends only on its own data, even when words run back to back.
- R11: In the data phase in_ready_o follows out_ready_i and out_valid_o follows in_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_code_i | input | 2 | Code select, sampled on the first symbol of a word |
| in_valid_i | input | 1 | Input symbol valid |
| in_ready_o | output | 1 | Input symbol accepted when high together with valid |
| in_data_i | input | 8 | Input data symbol |
| in_sow_i | input | 1 | Start-of-word flag on the input symbol |
| out_valid_o | output | 1 | Output symbol valid |
| out_ready_i | input | 1 | Downstream accepts the output symbol |
| out_data_o | output | 8 | Output symbol: data, then parity |
| out_sow_o | output | 1 | First symbol of an output codeword |
| out_eow_o | output | 1 | Last parity symbol of an output codeword |
| busy_o | output | 1 | A codeword is in progress |

## Verification
The bench changes cfg_code_i on nearly every cycle inside words. A design that sampled it outside the first symbol would emit the wrong number of parity symbols or the wrong values. Stray idle symbols and start flags placed mid-word check that a word neither opens early nor restarts, which would show up as misplaced out_sow_o or shortened words. A random word followed directly by an all-zero word must give all-zero parity, so a register that failed to clear would leak the earlier remainder. Stalls on both sides, including long parity backpressure, catch parity symbols that advance without a handshake and input accepted during parity.

// File: rtl/rs_var_pkg.sv
package rs_var_pkg;

  localparam int unsigned SYM_W   = 8;
  // x^8 folds onto x^4+x^3+x^2+1
  localparam logic [SYM_W-1:0] FIELD_LOW = 8'h1D;
  localparam int unsigned GEN_MAX = 64;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_PAR  = 2'd2
  } phase_e;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? FIELD_LOW : sym_t'(0));
    end
    return acc;
  endfunction

  // Coefficient idx of prod_{i<np} (x + alpha^i), low order first.
  function automatic sym_t gen_coef(int np, int idx);
    sym_t g [GEN_MAX+1];
    sym_t root;
    if (idx < 0 || idx > np || np > int'(GEN_MAX)) return '0;
    for (int j = 0; j <= int'(GEN_MAX); j++) g[j] = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < np; i++) begin
      for (int j = i + 1; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 8'h02);
    end
    return g[idx];
  endfunction

endpackage

// File: rtl/rs_var_lfsr.sv
module rs_var_lfsr
  import rs_var_pkg::*;
#(
  parameter  int unsigned NUM_CODES = 4,
  parameter  int unsigned PAR_BASE  = 2,
  localparam int unsigned CODE_W    = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              first_i,
  input  logic              take_i,
  input  logic              shift_i,
  input  sym_t              sym_i,
  output sym_t              par_o
);

  localparam int unsigned MAX_PAR = PAR_BASE << (NUM_CODES - 1);

  logic [MAX_PAR-1:0][SYM_W-1:0] regs_q, regs_d, below, prod;
  sym_t fb;

  // Active stages sit at the top; the start symbol sees a cleared register.
  assign fb    = sym_i ^ (first_i ? sym_t'(0) : regs_q[MAX_PAR-1]);
  assign par_o = regs_q[MAX_PAR-1];

  for (genvar j = 0; j < int'(MAX_PAR); j++) begin : g_stage
    sym_t by_code [NUM_CODES];

    if (j == 0) begin : g_bottom
      assign below[j] = '0;
    end else begin : g_upper
      assign below[j] = regs_q[j-1];
    end

    for (genvar c = 0; c < int'(NUM_CODES); c++) begin : g_code
      localparam int   NP  = int'(PAR_BASE) << c;
      localparam int   OFF = int'(MAX_PAR) - NP;
      localparam sym_t CF  = (j >= OFF) ? gen_coef(NP, j - OFF) : sym_t'(0);
      assign by_code[c] = gf_mul(fb, CF);
    end

    assign prod[j] = by_code[code_i];

    always_comb begin
      regs_d[j] = regs_q[j];
      if (take_i)       regs_d[j] = (first_i ? sym_t'(0) : below[j]) ^ prod[j];
      else if (shift_i) regs_d[j] = below[j];
    end

    // R2: stages below the selected parity count never hold a value mid-word
    a_r2_idle_stages_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!first_i && (j + (int'(PAR_BASE) << code_i) < int'(MAX_PAR))) |-> regs_q[j] == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else         regs_q <= regs_d;
  end

endmodule

// File: rtl/rs_var_ctrl.sv
module rs_var_ctrl
  import rs_var_pkg::*;
#(
  parameter  int unsigned NUM_CODES    = 4,
  parameter  int unsigned PAR_BASE     = 2,
  parameter  int unsigned DATA_PER_PAR = 8,
  localparam int unsigned CODE_W       = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              in_valid_i,
  input  logic              in_sow_i,
  input  logic              out_ready_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic              out_sow_o,
  output logic              out_eow_o,
  output logic              busy_o,
  output logic              first_o,
  output logic              take_o,
  output logic              shift_o,
  output logic              par_sel_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int unsigned MAX_K = (PAR_BASE * DATA_PER_PAR) << (NUM_CODES - 1);
  localparam int unsigned CNT_W = $clog2(MAX_K + 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q, code_d, code_eff;
  logic [CNT_W-1:0]  k_lim, np_lim;
  logic              sym_take, par_take;

  assign code_eff = (phase_q == PH_IDLE) ? cfg_code_i : code_q;
  assign k_lim    = CNT_W'(PAR_BASE * DATA_PER_PAR) << code_eff;
  assign np_lim   = CNT_W'(PAR_BASE) << code_eff;

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_sow_o   = 1'b0;
    out_eow_o   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        out_valid_o = in_valid_i & in_sow_i;
        in_ready_o  = in_sow_i ? out_ready_i : 1'b1;  // stray symbols are drained
        out_sow_o   = in_sow_i;
      end
      PH_DATA: begin
        out_valid_o = in_valid_i;
        in_ready_o  = out_ready_i;
      end
      PH_PAR: begin
        out_valid_o = 1'b1;
        out_eow_o   = (cnt_q == np_lim - CNT_W'(1));
      end
      default: ;
    endcase
  end

  assign sym_take = out_valid_o & out_ready_i & (phase_q != PH_PAR);
  assign par_take = (phase_q == PH_PAR) & out_ready_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    code_d  = code_q;
    unique case (phase_q)
      PH_IDLE: if (sym_take) begin
        phase_d = PH_DATA;
        cnt_d   = CNT_W'(1);
        code_d  = cfg_code_i;
      end
      PH_DATA: if (sym_take) begin
        if (cnt_q == k_lim - CNT_W'(1)) begin
          phase_d = PH_PAR;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_PAR: if (par_take) begin
        if (out_eow_o) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      code_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      code_q  <= code_d;
    end
  end

  assign busy_o    = (phase_q != PH_IDLE);
  assign first_o   = (phase_q == PH_IDLE);
  assign take_o    = sym_take;
  assign shift_o   = par_take;
  assign par_sel_o = (phase_q == PH_PAR);
  assign code_o    = code_eff;

  // R8: latched code stays put for the whole word
  a_r8_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(code_q));

  // R2: data count never reaches the word's data length
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA) |-> (cnt_q < (CNT_W'(PAR_BASE * DATA_PER_PAR) << code_q)));

  // R4: parity phase is entered only on an accepted data symbol
  a_r4_parity_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_PAR) |-> $past(sym_take));

endmodule

// File: rtl/rs_var_enc.sv
module rs_var_enc
  import rs_var_pkg::*;
#(
  parameter  int unsigned NUM_CODES    = 4,
  parameter  int unsigned PAR_BASE     = 2,
  parameter  int unsigned DATA_PER_PAR = 8,
  localparam int unsigned CODE_W       = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sow_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_sow_o,
  output logic              out_eow_o,
  output logic              busy_o
);

  logic              first, take, shift, par_sel;
  logic [CODE_W-1:0] code;
  sym_t              par;

  rs_var_ctrl #(
    .NUM_CODES   (NUM_CODES),
    .PAR_BASE    (PAR_BASE),
    .DATA_PER_PAR(DATA_PER_PAR)
  ) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_code_i (cfg_code_i),
    .in_valid_i (in_valid_i),
    .in_sow_i   (in_sow_i),
    .out_ready_i(out_ready_i),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .out_sow_o  (out_sow_o),
    .out_eow_o  (out_eow_o),
    .busy_o     (busy_o),
    .first_o    (first),
    .take_o     (take),
    .shift_o    (shift),
    .par_sel_o  (par_sel),
    .code_o     (code)
  );

  rs_var_lfsr #(
    .NUM_CODES(NUM_CODES),
    .PAR_BASE (PAR_BASE)
  ) lfsr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (code),
    .first_i(first),
    .take_i (take),
    .shift_i(shift),
    .sym_i  (in_data_i),
    .par_o  (par)
  );

  assign out_data_o = par_sel ? par : in_data_i;

  // R9: a word opens only on an accepted start-flagged symbol
  a_r9_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(in_valid_i && in_sow_i && out_ready_i));

  // R9: accepting the closing parity symbol ends the word
  a_r9_eow_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_eow_o && out_ready_i) |=> !busy_o);

  // R5: a stalled parity symbol holds
  a_r5_parity_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_sel && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: tb/rs_var_enc_tb.sv
`timescale 1ns/1ps
module rs_var_enc_tb_top;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cfg_code_i;
  logic       in_valid_i, in_sow_i, out_ready_i;
  logic [7:0] in_data_i;
  logic       in_ready_o, out_valid_o, out_sow_o, out_eow_o, busy_o;
  logic [7:0] out_data_o;

  always #2 clk = ~clk;  // 250 MHz

  rs_var_enc dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cfg_code_i (cfg_code_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .in_sow_i   (in_sow_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_sow_o  (out_sow_o),
    .out_eow_o  (out_eow_o),
    .busy_o     (busy_o)
  );

  int n_checks = 0, n_fail = 0;
  int exp_t [255];
  int log_t [256];
  logic [10:0] src_q [$];  // {code, sow, data}
  int vgap = 0, rgap = 0, cyc = 0;
  int ph = 0, mcode = 0, mk = 0, mnp = 0, mcnt = 0;
  int mdata [128];
  int mpar [16];
  bit mzero = 0;
  int seed = 32'h1357;

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 255];
  endfunction

  // Long division of m(x)*x^np by the generator, highest degree first.
  task automatic calc_parity();
    int gh [17];
    int a [144];
    int c;
    for (int j = 0; j < 17; j++) gh[j] = 0;
    gh[0] = 1;
    for (int i = 0; i < mnp; i++)
      for (int j = i + 1; j > 0; j--) gh[j] = gh[j] ^ gmul(gh[j-1], exp_t[i]);
    for (int i = 0; i < 144; i++) a[i] = (i < mk) ? mdata[i] : 0;
    for (int i = 0; i < mk; i++) begin
      c = a[i];
      if (c != 0)
        for (int j = 0; j <= mnp; j++) a[i+j] = a[i+j] ^ gmul(c, gh[j]);
    end
    for (int j = 0; j < mnp; j++) mpar[j] = a[mk+j];
    mzero = 1;
    for (int i = 0; i < mk; i++) if (mdata[i] != 0) mzero = 0;
  endtask

  task automatic model();
    case (ph)
      0: begin
        chk("R9", busy_o, 0);
        if (!in_valid_i) chk("R1", out_valid_o, 0);
        else if (!in_sow_i) begin
          chk("R6", in_ready_o, 1);
          chk("R6", out_valid_o, 0);
        end else begin
          chk("R3", out_valid_o, 1);
          chk("R3", out_data_o, in_data_i);
          chk("R3", out_sow_o, 1);
          chk("R11", in_ready_o, out_ready_i);
          if (out_ready_i) begin
            mcode = cfg_code_i;
            mk = 16 << mcode;
            mnp = 2 << mcode;
            mdata[0] = in_data_i;
            mcnt = 1;
            ph = 1;
          end
        end
      end
      1: begin
        chk("R9", busy_o, 1);
        chk("R11", out_valid_o, in_valid_i);
        chk("R11", in_ready_o, out_ready_i);
        if (in_valid_i) begin
          chk("R3", out_data_o, in_data_i);
          chk("R7", out_sow_o, 0);
          chk("R2", out_eow_o, 0);
          if (out_ready_i) begin
            mdata[mcnt] = in_data_i;
            mcnt++;
            if (mcnt == mk) begin
              calc_parity();
              ph = 2;
              mcnt = 0;
            end
          end
        end
      end
      default: begin
        chk("R9", busy_o, 1);
        chk("R5", in_ready_o, 0);
        chk("R5", out_valid_o, 1);
        chk("R5", out_sow_o, 0);
        chk(mcnt == 0 ? "R2" : "R4", out_data_o, mpar[mcnt]);
        if (mzero) chk("R10", out_data_o, 0);
        chk("R8", out_eow_o, (mcnt == mnp - 1) ? 1 : 0);
        if (out_ready_i) begin
          mcnt++;
          if (mcnt == mnp) ph = 0;
        end
      end
    endcase
  endtask

  task automatic step();
    logic [10:0] f;
    bit have;
    @(negedge clk);
    cyc++;
    have = (src_q.size() > 0);
    f = have ? src_q[0] : 11'd0;
    in_valid_i = have && (vgap == 0 || (cyc % vgap) != 0);
    in_sow_i   = f[8];
    in_data_i  = f[7:0];
    // code noise except on start-flagged symbols (R8)
    cfg_code_i = (have && f[8]) ? f[10:9] : 2'((cyc * 3 + (cyc >> 3)) % 4);
    out_ready_i = (rgap == 0 || (cyc % rgap) != 0);
    #1;
    model();
    if (in_valid_i && in_ready_o) void'(src_q.pop_front());
  endtask

  task automatic push_word(int code, int pat, bit mid_sow);
    int k;
    int d;
    bit s;
    k = 16 << code;
    for (int i = 0; i < k; i++) begin
      case (pat)
        0: d = 0;
        1: d = 8'hFF;
        2: d = i & 8'hFF;
        default: begin
          seed = seed * 1103515245 + 12345;
          d = (seed >>> 16) & 8'hFF;
        end
      endcase
      s = (i == 0) || (mid_sow && i == k / 2);
      src_q.push_back({(i == 0) ? 2'(code) : 2'(code + 1), s, 8'(d)});
    end
  endtask

  task automatic push_stray(int n);
    for (int i = 0; i < n; i++) src_q.push_back({2'd3, 1'b0, 8'(8'hA5 ^ i)});
  endtask

  task automatic drain();
    while (src_q.size() > 0 || ph != 0) step();
    repeat (2) step();
  endtask

  initial begin
    int x;
    x = 1;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = x;
      log_t[x] = i;
      x = x << 1;
      if (x & 32'h100) x = x ^ 32'h11D;
    end
    log_t[0] = 0;
  end

  initial begin
    in_valid_i = 0; in_sow_i = 0; in_data_i = 0; cfg_code_i = 0; out_ready_i = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1", busy_o, 0);
    chk("R1", out_valid_o, 0);
    chk("R1", in_ready_o, 1);
    repeat (2) step();

    // every code, free flow, random data
    for (int c = 0; c < 4; c++) begin
      push_word(c, 3, 0);
      drain();
    end
    // fixed patterns
    push_word(0, 1, 0); push_word(1, 2, 0); push_word(3, 1, 0); push_word(2, 2, 0);
    drain();
    // stalls on both sides
    vgap = 3; rgap = 4;
    for (int c = 0; c < 4; c++) push_word(c, 2, 0);
    drain();
    // stray idle symbols and mid-word start flags
    push_stray(5); push_word(1, 3, 1); push_stray(2); push_word(3, 3, 1); push_word(0, 3, 1);
    drain();
    // back-to-back, zero word after random ones
    vgap = 0; rgap = 0;
    push_word(2, 3, 0); push_word(2, 0, 0); push_word(3, 3, 0); push_word(0, 0, 0); push_word(3, 0, 0);
    drain();
    // heavy output backpressure
    rgap = 2;
    push_word(0, 2, 0); push_word(1, 1, 0); push_word(3, 3, 0);
    drain();
    rgap = 7; vgap = 2;
    push_word(2, 3, 0); push_word(0, 3, 0);
    drain();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule